// File: doc/BRIEF.md
# Chainable Interval Timer with Trigger Synchronization

This block is an up-counting interval timer controlled over a small register bus. A prescaler divides the core clock, and a period register sets how many prescaled ticks make up one cycle of the count. At the end of each cycle an update event fires. The update event reloads the buffered divider and period values, and it can be driven out as a trigger for other timers.

Timers are chained in two directions. Each timer picks one of several peer trigger lines, synchronizes it and uses it in one of two ways: as a level that gates counting, or as a rising edge that starts the counter. Each timer also drives one trigger output. The source of that output is chosen from a set of internal events and external compare references.

Top module: `tmr_chain_top`

## Requirements
- R1: With divider value P and period value A loaded, the update event repeats every (P+1)*(A+1) clock cycles. In master selection 2 the trigger output is high for exactly one cycle per update event.
- R2: The counter steps 0, 1, …, A. On the tick that finds it at or above A it wraps to 0, in the same cycle the update event is raised.
- R3: Control bit 1 (preload) set: a period write is held in a buffer until the next update event. Control bit 1 clear: a period write takes effect on the next tick, and a count already at or above the new value wraps to 0.
- R4: Writing 1 to bit 0 of the event register (address 6) forces an update event. It clears the counter and the prescaler phase, and it loads the written divider and period.
- R5: Control bit 0 (run) clear freezes the count. The count register (address 5) reads the live count and may be written at any time.
- R6: Slave selection 5 (gated): the counter advances only on cycles where the selected, two-flop-synchronized trigger is high.
- R7: Slave selection 6 (start): a rising edge on the synchronized selected trigger sets the run bit. A later edge does not restart or disturb a running count.
- R8: Slave register bits [5:4] select which trigger input is used. Activity on any other trigger input has no effect.
- R9: The trigger output is registered one cycle after its source. Master selection 0 gives a one-cycle pulse on a forced update. Selection 1 follows the run bit. Selection 3 follows the compare pulse input. Selections 4–7 follow compare references 0–3.
- R10: After reset all registers read zero, the counter is stopped and the trigger output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address (0 control, 1 master, 2 slave, 3 divider, 4 period, 5 count, 6 event) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| trig_in | input | N_TRIG | Peer trigger inputs, asynchronous |
| oc_ref | input | 4 | Compare reference levels |
| cmp_pulse | input | 1 | Compare pulse |
| trgo | output | 1 | Trigger output to peer timers |

## Verification
The hardest state to reach from the ports is a period write landing while the count is already above the new value. This matters because the preload bit decides whether the counter runs on to the old period or wraps at once. The bench stops the counter, writes the count directly to a value past the new period and changes the period. It then restarts and reads the count on each following cycle. Gated counting is checked to an exact tick count by holding the selected trigger high for a known number of cycles and allowing for the two-cycle synchronizer delay.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic [2:0] {
      A_CTRL   = 3'd0,
      A_MSTR   = 3'd1,
      A_SLV    = 3'd2,
      A_DIV    = 3'd3,
      A_PERIOD = 3'd4,
      A_COUNT  = 3'd5,
      A_EVT    = 3'd6
   } reg_addr_e;

   typedef enum logic [2:0] {
      MM_RESET  = 3'd0,
      MM_ENABLE = 3'd1,
      MM_UPDATE = 3'd2,
      MM_CMP    = 3'd3,
      MM_REF0   = 3'd4,
      MM_REF1   = 3'd5,
      MM_REF2   = 3'd6,
      MM_REF3   = 3'd7
   } master_sel_e;

   localparam logic [2:0] SLV_GATED = 3'd5;
   localparam logic [2:0] SLV_START = 3'd6;
endpackage

// File: rtl/tmr_trig_in.sv
module tmr_trig_in #(
   parameter int N_TRIG = 4,
   parameter int SEL_W  = (N_TRIG > 1) ? $clog2(N_TRIG) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_TRIG-1:0] trig_raw,
   input  logic [SEL_W-1:0]  sel,
   output logic              lvl,
   output logic              rise
);
   logic [N_TRIG-1:0] meta_q;
   logic [N_TRIG-1:0] sync_q;
   logic              prev_q;

   genvar gi;
   generate
      for (gi = 0; gi < N_TRIG; gi++) begin : g_sync
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               meta_q[gi] <= 1'b0;
               sync_q[gi] <= 1'b0;
            end else begin
               meta_q[gi] <= trig_raw[gi];
               sync_q[gi] <= meta_q[gi];
            end
         end
      end
   endgenerate

   assign lvl = sync_q[sel];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl;
   end

   assign rise = lvl & ~prev_q;

   // R7: an edge is reported for one cycle only
   a_r7_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
   parameter int CNT_W = 16,
   parameter int PSC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic             gate_ok,
   input  logic             arpe,
   input  logic [PSC_W-1:0] psc_reg,
   input  logic [CNT_W-1:0] arr_reg,
   input  logic             ug,
   input  logic             cnt_wr,
   input  logic [CNT_W-1:0] cnt_wdata,
   output logic [CNT_W-1:0] cnt,
   output logic             uev
);
   logic [PSC_W-1:0] psc_act_q;
   logic [PSC_W-1:0] phase_q;
   logic [CNT_W-1:0] arr_shd_q;
   logic [CNT_W-1:0] arr_act;
   logic             run;
   logic             tick;
   logic             ovf;

   assign arr_act = arpe ? arr_shd_q : arr_reg;
   assign run     = run_en & gate_ok;
   assign tick    = run & (phase_q >= psc_act_q);
   assign ovf     = tick & (cnt >= arr_act);
   assign uev     = ovf | ug;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (ug) begin
         phase_q <= '0;
      end else if (run) begin
         phase_q <= tick ? '0 : phase_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (ug) begin
         cnt <= '0;
      end else if (cnt_wr) begin
         cnt <= cnt_wdata;
      end else if (ovf) begin
         cnt <= '0;
      end else if (tick) begin
         cnt <= cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         psc_act_q <= '0;
         arr_shd_q <= '0;
      end else begin
         if (uev) psc_act_q <= psc_reg;
         if (uev || !arpe) arr_shd_q <= arr_reg;
      end
   end

   a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !ug && !cnt_wr) |=> (cnt == '0));

   a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !ovf && !ug && !cnt_wr) |=> (cnt == $past(cnt) + 1'b1));

   a_r4_force_restart: assert property (@(posedge clk) disable iff (!rst_n)
      ug |=> (cnt == '0 && phase_q == '0));

   a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !ug && !cnt_wr) |=> $stable(cnt));

   a_r3_buffer_held: assert property (@(posedge clk) disable iff (!rst_n)
      (arpe && !uev) |=> $stable(arr_shd_q));
endmodule

// File: rtl/tmr_trgo_sel.sv
module tmr_trgo_sel
   import tmr_pkg::*;
#(
   parameter int N_REF = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       mode,
   input  logic             ug,
   input  logic             run_en,
   input  logic             uev,
   input  logic             cmp_pulse,
   input  logic [N_REF-1:0] oc_ref,
   output logic             trgo
);
   logic src;

   always_comb begin
      case (master_sel_e'(mode))
         MM_RESET:  src = ug;
         MM_ENABLE: src = run_en;
         MM_UPDATE: src = uev;
         MM_CMP:    src = cmp_pulse;
         default:   src = oc_ref[mode[1:0]];
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trgo <= 1'b0;
      else        trgo <= src;
   end

   // R9: in reset selection the output only rises after a forced update
   a_r9_reset_pulse_only: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MM_RESET && !ug) |=> !trgo);
endmodule

// File: rtl/tmr_chain_top.sv
module tmr_chain_top
   import tmr_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 16,
   parameter int PSC_W  = 16,
   parameter int N_TRIG = 4,
   localparam int SEL_W = (N_TRIG > 1) ? $clog2(N_TRIG) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [2:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [N_TRIG-1:0] trig_in,
   input  logic [3:0]        oc_ref,
   input  logic              cmp_pulse,
   output logic              trgo
);
   localparam int TS_LSB = 4;

   initial begin
      assert (CNT_W >= 1 && CNT_W <= DATA_W) else $error("CNT_W out of range");
      assert (PSC_W >= 1 && PSC_W <= DATA_W) else $error("PSC_W out of range");
      assert (TS_LSB + SEL_W <= DATA_W) else $error("slave field too wide");
      assert (N_TRIG >= 1) else $error("need at least one trigger");
   end

   logic             run_q;
   logic             arpe_q;
   logic [2:0]       mstr_q;
   logic [2:0]       sms_q;
   logic [SEL_W-1:0] ts_q;
   logic [PSC_W-1:0] psc_q;
   logic [CNT_W-1:0] arr_q;
   logic [CNT_W-1:0] cnt;
   logic             uev;
   logic             trig_lvl;
   logic             trig_rise;
   logic             gate_ok;
   logic             ug;
   logic             cnt_wr;

   assign ug      = bus_wr && (bus_addr == A_EVT) && bus_wdata[0];
   assign cnt_wr  = bus_wr && (bus_addr == A_COUNT);
   assign gate_ok = (sms_q != SLV_GATED) || trig_lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         arpe_q <= 1'b0;
         mstr_q <= '0;
         sms_q  <= '0;
         ts_q   <= '0;
         psc_q  <= '0;
         arr_q  <= '0;
      end else begin
         if (bus_wr) begin
            case (reg_addr_e'(bus_addr))
               A_CTRL: begin
                  run_q  <= bus_wdata[0];
                  arpe_q <= bus_wdata[1];
               end
               A_MSTR:   mstr_q <= bus_wdata[2:0];
               A_SLV: begin
                  sms_q <= bus_wdata[2:0];
                  ts_q  <= bus_wdata[TS_LSB +: SEL_W];
               end
               A_DIV:    psc_q <= bus_wdata[PSC_W-1:0];
               A_PERIOD: arr_q <= bus_wdata[CNT_W-1:0];
               default: ;
            endcase
         end
         if (sms_q == SLV_START && trig_rise) run_q <= 1'b1;
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (reg_addr_e'(bus_addr))
         A_CTRL:   bus_rdata = DATA_W'({arpe_q, run_q});
         A_MSTR:   bus_rdata = DATA_W'(mstr_q);
         A_SLV: begin
            bus_rdata[2:0]              = sms_q;
            bus_rdata[TS_LSB +: SEL_W]  = ts_q;
         end
         A_DIV:    bus_rdata = DATA_W'(psc_q);
         A_PERIOD: bus_rdata = DATA_W'(arr_q);
         A_COUNT:  bus_rdata = DATA_W'(cnt);
         default:  bus_rdata = '0;
      endcase
   end

   tmr_trig_in #(.N_TRIG(N_TRIG), .SEL_W(SEL_W)) trig_i (
      .clk(clk), .rst_n(rst_n), .trig_raw(trig_in), .sel(ts_q),
      .lvl(trig_lvl), .rise(trig_rise)
   );

   tmr_count_core #(.CNT_W(CNT_W), .PSC_W(PSC_W)) core_i (
      .clk(clk), .rst_n(rst_n), .run_en(run_q), .gate_ok(gate_ok),
      .arpe(arpe_q), .psc_reg(psc_q), .arr_reg(arr_q), .ug(ug),
      .cnt_wr(cnt_wr), .cnt_wdata(bus_wdata[CNT_W-1:0]),
      .cnt(cnt), .uev(uev)
   );

   tmr_trgo_sel #(.N_REF(4)) trgo_i (
      .clk(clk), .rst_n(rst_n), .mode(mstr_q), .ug(ug), .run_en(run_q),
      .uev(uev), .cmp_pulse(cmp_pulse), .oc_ref(oc_ref), .trgo(trgo)
   );

   a_r7_start_sets_run: assert property (@(posedge clk) disable iff (!rst_n)
      (sms_q == SLV_START && trig_rise) |=> run_q);

   a_r6_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (sms_q == SLV_GATED && !trig_lvl && !ug && !cnt_wr) |=> $stable(cnt));
endmodule

// File: tb/tmr_chain_top_tb.sv
module tmr_chain_top_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 7;
   localparam int WIN = 96;
   localparam logic [15:0] V_PSC [NV] = '{16'd0, 16'd0, 16'd1, 16'd2, 16'd3, 16'd0, 16'd5};
   localparam logic [15:0] V_ARR [NV] = '{16'd0, 16'd3, 16'd3, 16'd1, 16'd5, 16'd7, 16'd1};
   localparam int          V_EXP [NV] = '{96, 24, 12, 16, 4, 12, 8};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [3:0]  trig_in = '0;
   logic [3:0]  oc_ref = '0;
   logic        cmp_pulse = 1'b0;
   logic        trgo;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tmr_chain_top dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trig_in(trig_in),
      .oc_ref(oc_ref), .cmp_pulse(cmp_pulse), .trgo(trgo)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output int d);
      bus_addr = a;
      #1;
      d = int'(bus_rdata);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int v, c1, c2, n, e;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R10: reset state
      for (int a = 0; a < 6; a++) begin
         rd(3'(a), v);
         chk("R10 reg zero", v, 0);
      end
      chk("R10 trgo low", int'(trgo), 0);
      repeat (3) @(negedge clk);
      rd(3'd5, v);
      chk("R10 stopped", v, 0);

      // R1: update rate table, trigger output in update selection
      for (int i = 0; i < NV; i++) begin
         wr(3'd0, 16'd0);
         wr(3'd2, 16'd0);
         wr(3'd1, 16'd2);
         wr(3'd3, V_PSC[i]);
         wr(3'd4, V_ARR[i]);
         wr(3'd6, 16'd1);
         wr(3'd0, 16'd1);
         repeat (3) @(negedge clk);
         n = 0;
         for (int k = 0; k < WIN; k++) begin
            @(negedge clk);
            if (trgo) n++;
         end
         chk("R1 update pulses", n, V_EXP[i]);
      end

      // R2: count sequence and wrap
      wr(3'd0, 16'd0);
      wr(3'd3, 16'd0);
      wr(3'd4, 16'd2);
      wr(3'd6, 16'd1);
      wr(3'd0, 16'd1);
      e = 0;
      for (int k = 0; k < 9; k++) begin
         @(negedge clk);
         e = (e == 2) ? 0 : e + 1;
         rd(3'd5, v);
         chk("R2 count step", v, e);
      end

      // R3: preload on, new period waits for update
      wr(3'd0, 16'd2);
      wr(3'd4, 16'd9);
      wr(3'd6, 16'd1);
      wr(3'd5, 16'd5);
      wr(3'd4, 16'd3);
      wr(3'd0, 16'd3);
      repeat (3) @(negedge clk);
      rd(3'd5, v);
      chk("R3 buffered period", v, 8);
      // R3: preload off, immediate period wraps a higher count
      wr(3'd0, 16'd0);
      wr(3'd5, 16'd5);
      wr(3'd0, 16'd1);
      @(negedge clk);
      rd(3'd5, v);
      chk("R3 immediate period", v, 0);

      // R5: stopped count holds; count writable
      wr(3'd0, 16'd0);
      wr(3'd5, 16'h1234);
      rd(3'd5, c1);
      chk("R5 count write", c1, 16'h1234);
      repeat (5) @(negedge clk);
      rd(3'd5, c2);
      chk("R5 hold", c2, c1);

      // R4: forced update clears count
      wr(3'd3, 16'd3);
      wr(3'd6, 16'd1);
      rd(3'd5, v);
      chk("R4 force clears", v, 0);

      // R8 / R6: gated on input 2
      wr(3'd1, 16'd0);
      wr(3'd3, 16'd0);
      wr(3'd4, 16'd1000);
      wr(3'd2, 16'h0025);
      wr(3'd6, 16'd1);
      wr(3'd0, 16'd1);
      trig_in[1] = 1'b1;
      repeat (10) @(negedge clk);
      trig_in[1] = 1'b0;
      repeat (4) @(negedge clk);
      rd(3'd5, v);
      chk("R8 unselected ignored", v, 0);
      @(negedge clk);
      trig_in[2] = 1'b1;
      repeat (10) @(negedge clk);
      trig_in[2] = 1'b0;
      repeat (5) @(negedge clk);
      rd(3'd5, v);
      chk("R6 gated ticks", v, 10);

      // R7: start on edge of input 0
      wr(3'd0, 16'd0);
      wr(3'd2, 16'h0006);
      wr(3'd6, 16'd1);
      trig_in[0] = 1'b1;
      repeat (2) @(negedge clk);
      trig_in[0] = 1'b0;
      repeat (4) @(negedge clk);
      rd(3'd0, v);
      chk("R7 run set", v & 1, 1);
      rd(3'd5, c1);
      chk("R7 counting", int'(c1 > 0), 1);
      @(negedge clk);
      trig_in[0] = 1'b1;
      repeat (3) @(negedge clk);
      trig_in[0] = 1'b0;
      repeat (4) @(negedge clk);
      rd(3'd5, c2);
      chk("R7 later edge ignored", c2, c1 + 8);

      // R9: master selections
      wr(3'd0, 16'd0);
      wr(3'd2, 16'd0);
      wr(3'd1, 16'd1);
      repeat (2) @(negedge clk);
      chk("R9 enable low", int'(trgo), 0);
      wr(3'd0, 16'd1);
      @(negedge clk);
      chk("R9 enable high", int'(trgo), 1);
      wr(3'd0, 16'd0);
      wr(3'd1, 16'd3);
      cmp_pulse = 1'b1;
      @(negedge clk);
      chk("R9 compare high", int'(trgo), 1);
      cmp_pulse = 1'b0;
      @(negedge clk);
      chk("R9 compare low", int'(trgo), 0);
      for (int j = 0; j < 4; j++) begin
         oc_ref = 4'(1 << j);
         wr(3'd1, 16'(4 + j));
         @(negedge clk);
         chk("R9 ref high", int'(trgo), 1);
         oc_ref = ~4'(1 << j);
         @(negedge clk);
         chk("R9 ref low", int'(trgo), 0);
      end
      oc_ref = '0;
      wr(3'd1, 16'd0);
      @(negedge clk);
      chk("R9 reset idle", int'(trgo), 0);
      wr(3'd6, 16'd1);
      chk("R9 reset pulse", int'(trgo), 1);
      @(negedge clk);
      chk("R9 reset pulse end", int'(trgo), 0);

      finish_run();
   end
endmodule